// File: doc/BRIEF.md
# Memory protection region permission checker

The block keeps a small table of protection regions and answers one question per request: may unprivileged software read, or write, the whole of a buffer given by its start address and its length in bytes? Each region holds a base address, a size code, an enable bit and a 3-bit access-permission code. Software fills the table through a three-word register write port. The table is not read back.

A request is one cycle with `req_valid` high. The table lookup is combinational. The answer is registered and shows on `rsp_valid`/`rsp_grant` one clock after the strobe. Among the enabled regions that hold every byte of the buffer, the one with the highest index decides. If no enabled region holds the buffer, the access is denied. The region count `NUM_REGIONS` is a power of two from 2 to 16 and defaults to 8.

The reset input `rst_n` is asserted asynchronously and released through a two-flop synchroniser. Requests should start only a few cycles after release.

Top module: `prot_region_checker`

## Requirements
- R1: Reset disables every region and sets the selected-region register to 0. Until software programs the table, every request is answered with `rsp_grant` = 0. A base write without the valid flag, made straight after reset, goes to region 0.
- R2: Register port (`cfg_wr` high for one cycle):
  - `cfg_sel` = 0 loads the selected-region register from `cfg_wdata[3:0]`, using only its low log2(NUM_REGIONS) bits.
  - `cfg_sel` = 1 writes the base address `cfg_wdata[31:5]` (bits 4:0 read as zero). If bit 4 (the valid flag) is 1, the entry is chosen by `cfg_wdata[3:0]`, and that index is also loaded into the selected-region register. Otherwise the write goes to the selected entry.
  - `cfg_sel` = 2 writes the selected entry's attribute word: bit 0 is the enable bit, bits 5:1 the size code, bits 26:24 the permission code.
- R3: A region with size code c covers 2^(c+1) bytes, starting at its base address with the base's bits below that size ignored. Codes 0 to 3 behave as code 4 (32 bytes). Code 31 covers the whole 4 GB space.
- R4: A buffer is contained in a region only if both its first byte (start) and its last byte (start + length - 1) lie in the region. A zero-length request is denied. So is a request whose last byte would lie beyond address 0xFFFFFFFF.
- R5: A region whose enable bit is 0 takes no part in the lookup, whatever its other fields hold. If no enabled region contains the buffer, the access is denied.
- R6: When several enabled regions contain the buffer, the highest-numbered one alone decides, even where a lower one would grant.
- R7: A write (`req_write` = 1) is granted only when the deciding region's permission code is exactly 3'b011.
- R8: A read (`req_write` = 0) is granted whenever bit 1 of the deciding region's permission code is 1, that is for codes 2, 3, 6 and 7.
- R9: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. `rsp_grant` is 0 whenever `rsp_valid` is 0.
- R10: Writing the all-zero word to a region's attribute word disables that region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 region number, 1 base, 2 attribute |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Buffer start address |
| req_len | input | 32 | Buffer length in bytes |
| req_write | input | 1 | 1 = write check, 0 = read check |
| rsp_valid | output | 1 | Answer valid, one cycle after the strobe |
| rsp_grant | output | 1 | 1 = access granted |

## Verification
Some rules are checked by assertions on every cycle:
- the response timing;
- the denial of zero-length requests and of requests that no region holds;
- the rule that a granted write needs the full read/write code;
- the shape of the priority pick, namely that the winner contains the buffer and no higher-numbered region does;
- the disabling effect of an all-zero attribute write;
- the selection side effect of a flagged base write.

Other behaviour only the bench scenarios can show, because it depends on the contents of the whole table: the size arithmetic, including the clamping of small codes and the full-space code; containment exactly at a region's edges and across the top of the address space; the read decode of each permission code; and which region wins where regions overlap. Random overlapping tables are compared against an independent model to cover those cases.

// File: rtl/prc_pkg.sv
package prc_pkg;
  localparam int ADDR_W = 32;
  localparam int MIN_CODE = 4;
  localparam int VALID_BIT = 4;
  localparam int EN_BIT = 0;
  localparam int CODE_LSB = 1;
  localparam int AP_LSB = 24;
  localparam logic [2:0] AP_FULL_RW = 3'b011;

  typedef enum logic [1:0] {
    SEL_RNR  = 2'd0,
    SEL_BASE = 2'd1,
    SEL_ATTR = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [4:0]        code;
    logic              en;
    logic [2:0]        ap;
  } region_t;
endpackage

// File: rtl/prc_regfile.sv
module prc_regfile
  import prc_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_wr,
  input  logic [1:0]                    cfg_sel,
  input  logic [31:0]                   cfg_wdata,
  output region_t [NUM_REGIONS-1:0]     regions
);
  localparam int IDXW = $clog2(NUM_REGIONS);

  logic [IDXW-1:0]   rnr_q, rnr_d, tgt;
  logic              base_we, attr_we;
  logic [NUM_REGIONS-1:0] en_q;
  logic [ADDR_W-1:0] base_q [NUM_REGIONS];
  logic [4:0]        code_q [NUM_REGIONS];
  logic [2:0]        ap_q   [NUM_REGIONS];
  logic              unused_wdata;

  assign unused_wdata = ^cfg_wdata;

  // next-state decode of the register port
  always_comb begin
    rnr_d   = rnr_q;
    tgt     = rnr_q;
    base_we = 1'b0;
    attr_we = 1'b0;
    if (cfg_wr) begin
      case (cfg_sel_e'(cfg_sel))
        SEL_RNR:  rnr_d = cfg_wdata[IDXW-1:0];
        SEL_BASE: begin
          base_we = 1'b1;
          if (cfg_wdata[VALID_BIT]) begin
            tgt   = cfg_wdata[IDXW-1:0];
            rnr_d = cfg_wdata[IDXW-1:0];
          end
        end
        SEL_ATTR: attr_we = 1'b1;
        default:  ;
      endcase
    end
  end

  // control state: reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rnr_q <= '0;
      en_q  <= '0;
    end else begin
      rnr_q <= rnr_d;
      if (attr_we) en_q[tgt] <= cfg_wdata[EN_BIT];
    end
  end

  // data state: no reset, gated by the enable bit
  always_ff @(posedge clk) begin
    if (base_we) base_q[tgt] <= {cfg_wdata[ADDR_W-1:5], 5'b0};
    if (attr_we) begin
      code_q[tgt] <= cfg_wdata[CODE_LSB +: 5];
      ap_q[tgt]   <= cfg_wdata[AP_LSB +: 3];
    end
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_pack
    assign regions[g] = '{base: base_q[g], code: code_q[g], en: en_q[g], ap: ap_q[g]};
  end

  // R10: an all-zero attribute word leaves the selected region disabled
  p_zero_attr_disables_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_sel == SEL_ATTR && cfg_wdata == 32'd0) |=> !en_q[$past(rnr_q)]);

  // R2: a flagged base write moves the selection to its index field
  p_flagged_base_selects_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_sel == SEL_BASE && cfg_wdata[VALID_BIT])
      |=> rnr_q == $past(cfg_wdata[IDXW-1:0]));
endmodule

// File: rtl/prc_region_match.sv
module prc_region_match
  import prc_pkg::*;
(
  input  logic [ADDR_W-1:0] base,
  input  logic [4:0]        code,
  input  logic              en,
  input  logic              span_ok,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic [ADDR_W-1:0] last_addr,
  output logic              hit
);
  logic [4:0]        eff_code;
  logic [ADDR_W:0]   span;
  logic [ADDR_W-1:0] mask;

  always_comb begin
    eff_code = (code < 5'(MIN_CODE)) ? 5'(MIN_CODE) : code;
    span     = (ADDR_W+1)'(1) << ({1'b0, eff_code} + 6'd1);
    mask     = ~(span[ADDR_W-1:0] - ADDR_W'(1));
    hit      = en && span_ok
               && (((first_addr ^ base) & mask) == '0)
               && (((last_addr  ^ base) & mask) == '0);
  end
endmodule

// File: rtl/prc_priority.sv
module prc_priority #(
  parameter int NUM_REGIONS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_REGIONS-1:0]      hits,
  input  logic [NUM_REGIONS-1:0][2:0] ap_vec,
  output logic                        found,
  output logic [2:0]                  win_ap
);
  localparam int IDXW = $clog2(NUM_REGIONS);

  logic [IDXW-1:0] win_idx;

  // ascending scan: a later (higher) hit overrides an earlier one
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (hits[i]) begin
        found   = 1'b1;
        win_idx = i[IDXW-1:0];
      end
    end
    win_ap = ap_vec[win_idx];
  end

  // R6: the winner is a hit and nothing above it hits
  p_winner_is_highest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (hits[win_idx] && ((hits >> win_idx) == NUM_REGIONS'(1))));
  // R5: no hit means no winner
  p_no_hit_no_winner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hits == '0) |-> !found);
endmodule

// File: rtl/prot_region_checker.sv
module prot_region_checker
  import prc_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_len,
  input  logic        req_write,
  output logic        rsp_valid,
  output logic        rsp_grant
);
  logic                        rst_meta_n, rst_sync_n;
  region_t [NUM_REGIONS-1:0]   regions;
  logic [NUM_REGIONS-1:0]      hits;
  logic [NUM_REGIONS-1:0][2:0] ap_vec;
  logic [ADDR_W:0]             last_w;
  logic                        span_ok, found, grant_c;
  logic [2:0]                  win_ap;
  logic                        rsp_valid_d, rsp_grant_d;
  logic                        rsp_valid_q, rsp_grant_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  prc_regfile #(.NUM_REGIONS(NUM_REGIONS)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .regions(regions)
  );

  assign last_w  = {1'b0, req_addr} + {1'b0, req_len} - (ADDR_W+1)'(1);
  assign span_ok = (req_len != '0) && !last_w[ADDR_W];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
    prc_region_match u_match (
      .base(regions[g].base), .code(regions[g].code), .en(regions[g].en),
      .span_ok(span_ok), .first_addr(req_addr), .last_addr(last_w[ADDR_W-1:0]),
      .hit(hits[g])
    );
    assign ap_vec[g] = regions[g].ap;
  end

  prc_priority #(.NUM_REGIONS(NUM_REGIONS)) u_pick (
    .clk(clk), .rst_n(rst_sync_n), .hits(hits), .ap_vec(ap_vec),
    .found(found), .win_ap(win_ap)
  );

  // permission decode and response next state
  always_comb begin
    grant_c     = found && (req_write ? (win_ap == AP_FULL_RW) : win_ap[1]);
    rsp_valid_d = req_valid;
    rsp_grant_d = req_valid && grant_c;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid_q <= 1'b0;
      rsp_grant_q <= 1'b0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_grant_q <= rsp_grant_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_grant = rsp_grant_q;

  // R9: response one cycle after each strobe, silent otherwise
  p_rsp_after_req_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> rsp_valid);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> (!rsp_valid && !rsp_grant));
  // R4: zero-length requests are denied
  p_zero_len_denied_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_len == '0) |=> !rsp_grant);
  // R5: nothing contains the buffer -> deny
  p_no_hit_denied_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && hits == '0) |=> !rsp_grant);
  // R7: a granted write needs the full read/write code in the winner
  p_write_needs_full_rw_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_write && win_ap != AP_FULL_RW) |=> !rsp_grant);
endmodule

// File: tb/prot_region_checker_tb.sv
`timescale 1ns/1ps
module prot_region_checker_tb;
  localparam int NR = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr;
  logic [1:0] cfg_sel;
  logic [31:0] cfg_wdata;
  logic req_valid, req_write;
  logic [31:0] req_addr, req_len;
  logic rsp_valid, rsp_grant;

  always #2.5 clk = ~clk;

  prot_region_checker #(.NUM_REGIONS(NR)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_grant(rsp_grant)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model of the table
  logic        m_en   [NR];
  logic [31:0] m_base [NR];
  logic [4:0]  m_code [NR];
  logic [2:0]  m_ap   [NR];
  logic [2:0]  m_rnr;

  function automatic logic [31:0] mk_attr(logic en, logic [4:0] code, logic [2:0] ap);
    return {5'b0, ap, 18'b0, code, en};
  endfunction

  function automatic logic exp_grant(logic [31:0] a, logic [31:0] l, logic wr);
    logic [63:0] s, e, sz, b;
    logic [4:0] c;
    logic hit = 1'b0;
    logic [2:0] ap = 3'd0;
    s = {32'd0, a};
    e = s + {32'd0, l} - 64'd1;
    for (int i = 0; i < NR; i++) begin
      if (m_en[i] && l != 0 && e <= 64'hFFFF_FFFF) begin
        c  = (m_code[i] < 5'd4) ? 5'd4 : m_code[i];
        sz = 64'd1 << (c + 1);
        b  = {32'd0, m_base[i]} & ~(sz - 64'd1);
        if (s >= b && e <= b + sz - 64'd1) begin
          hit = 1'b1;
          ap  = m_ap[i];
        end
      end
    end
    return hit && (wr ? (ap == 3'b011) : ap[1]);
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic cfg(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    case (sel)
      2'd0: m_rnr = d[2:0];
      2'd1: begin
        if (d[4]) m_rnr = d[2:0];
        m_base[m_rnr] = {d[31:5], 5'b0};
      end
      2'd2: begin
        m_en[m_rnr] = d[0]; m_code[m_rnr] = d[5:1]; m_ap[m_rnr] = d[26:24];
      end
      default: ;
    endcase
  endtask

  task automatic req(logic [31:0] a, logic [31:0] l, logic wr, logic exp, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_len = l; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 rsp_valid after strobe", rsp_valid, 1'b1);
    chk(tag, rsp_grant, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [4:0] c;
    logic [2:0] idx;
    r = $urandom(32'd20240611);
    for (int i = 0; i < NR; i++) begin
      m_en[i] = 1'b0; m_base[i] = '0; m_code[i] = '0; m_ap[i] = '0;
    end
    m_rnr = '0;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0; req_len = '0; req_write = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 rsp_valid in reset", rsp_valid, 1'b0);
    chk("R1 rsp_grant in reset", rsp_grant, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: empty table denies, unflagged base write lands in region 0
    req(32'h0, 32'd4, 1'b0, 1'b0, "R1 empty table read");
    cfg(2'd1, 32'h0000_2000);
    cfg(2'd2, mk_attr(1'b1, 5'd8, 3'b011));
    req(32'h2000, 32'd16, 1'b1, 1'b1, "R1 region0 selected after reset");
    cfg(2'd2, 32'd0);

    // random overlapping tables against the model
    for (int round = 0; round < 40; round++) begin
      for (int k = 0; k < 3; k++) begin
        idx = 3'($urandom_range(0, NR - 1));
        c   = 5'($urandom_range(2, 15));
        r   = $urandom & 32'h0001_FFFF;
        r   = r & ~((32'd1 << (c + 1)) - 32'd1);
        if ($urandom_range(0, 1) == 1) cfg(2'd1, r | 32'h10 | {29'd0, idx});
        else begin
          cfg(2'd0, {29'd0, idx});
          cfg(2'd1, r);
        end
        cfg(2'd2, mk_attr($urandom_range(0, 4) != 0, c, 3'($urandom_range(0, 7))));
      end
      for (int k = 0; k < 8; k++) begin
        logic [31:0] a, l;
        logic wr;
        a  = $urandom & 32'h0001_FFFF;
        l  = ($urandom_range(0, 9) == 0) ? 32'd0 : 32'($urandom_range(1, 1024));
        wr = 1'($urandom_range(0, 1));
        req(a, l, wr, exp_grant(a, l, wr), "R6 random overlap vs model");
      end
    end

    // clear the table (R10)
    for (int i = 0; i < NR; i++) begin
      cfg(2'd0, i);
      cfg(2'd2, 32'd0);
    end
    req(32'h100, 32'd8, 1'b0, 1'b0, "R10 cleared table denies");

    // region 0: whole space, full read/write
    cfg(2'd1, 32'h0000_0010);
    cfg(2'd2, mk_attr(1'b1, 5'd31, 3'b011));
    req(32'h1234_5678, 32'd8, 1'b0, 1'b1, "R3 code 31 read");
    req(32'h1234_5678, 32'd8, 1'b1, 1'b1, "R7 full rw write");
    // region 5: 4 KB at 0x1000, unprivileged read only
    cfg(2'd1, 32'h0000_1015);
    cfg(2'd2, mk_attr(1'b1, 5'd11, 3'b010));
    req(32'h1000, 32'd16, 1'b1, 1'b0, "R6 higher region denies write");
    req(32'h1000, 32'd16, 1'b0, 1'b1, "R8 code 2 read");
    req(32'h1FF8, 32'd16, 1'b1, 1'b1, "R4 straddle leaves region 5");
    req(32'h1FF0, 32'd16, 1'b1, 1'b0, "R4 last byte at region end");
    req(32'h0100, 32'd0,  1'b0, 1'b0, "R4 zero length");
    req(32'hFFFF_FFF0, 32'h20, 1'b0, 1'b0, "R4 wrap past top");
    req(32'hFFFF_FFF0, 32'h10, 1'b0, 1'b1, "R4 ends at top");
    // region 6: code 2 acts as 32 bytes, no access
    cfg(2'd1, 32'h0000_4016);
    cfg(2'd2, mk_attr(1'b1, 5'd2, 3'b000));
    req(32'h401F, 32'd1, 1'b0, 1'b0, "R3 small code clamps to 32B inside");
    req(32'h4020, 32'd1, 1'b0, 1'b1, "R3 small code clamps to 32B outside");
    cfg(2'd2, mk_attr(1'b1, 5'd4, 3'b001));
    req(32'h4000, 32'd4, 1'b0, 1'b0, "R8 code 1 read denied");
    cfg(2'd2, mk_attr(1'b1, 5'd4, 3'b110));
    req(32'h4000, 32'd4, 1'b0, 1'b1, "R8 code 6 read");
    req(32'h4000, 32'd4, 1'b1, 1'b0, "R7 code 6 write denied");
    cfg(2'd2, mk_attr(1'b1, 5'd4, 3'b111));
    req(32'h4000, 32'd4, 1'b1, 1'b0, "R7 code 7 write denied");
    req(32'h4000, 32'd4, 1'b0, 1'b1, "R8 code 7 read");
    // R10: zero attribute word on region 5
    cfg(2'd0, 32'd5);
    cfg(2'd2, 32'd0);
    req(32'h1000, 32'd16, 1'b1, 1'b1, "R10 region 5 cleared");
    // R2: unflagged base write follows the selected register
    cfg(2'd0, 32'd7);
    cfg(2'd1, 32'h0000_8003);
    cfg(2'd2, mk_attr(1'b1, 5'd4, 3'b000));
    req(32'h8000, 32'd4, 1'b0, 1'b0, "R2 base write to selected entry 7");
    req(32'h8020, 32'd4, 1'b0, 1'b1, "R2 region 7 only 32 bytes");
    // R5: disabled regions ignored
    cfg(2'd0, 32'd0);
    cfg(2'd2, mk_attr(1'b0, 5'd31, 3'b011));
    req(32'h9000, 32'd4, 1'b0, 1'b0, "R5 no enabled region");
    cfg(2'd0, 32'd7);
    cfg(2'd2, mk_attr(1'b0, 5'd4, 3'b011));
    req(32'h8000, 32'd4, 1'b0, 1'b0, "R5 disabled region with rw code");
    // R9: quiet cycle after a response
    @(negedge clk);
    chk("R9 rsp_valid idle", rsp_valid, 1'b0);
    chk("R9 rsp_grant idle", rsp_grant, 1'b0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule